// File: doc/BRIEF.md
# CAN Acceptance Filter with Scalable Banks

This block decides, for every received CAN frame, whether the frame is kept or dropped, and which filter accepted it. The receive path presents the frame's 11-bit base identifier, its 18-bit identifier extension, the IDE flag and the RTR flag together with a one-cycle strobe. One clock later the block answers with a result strobe, an accept flag and the global number of the filter that accepted the frame. A frame that no filter accepts is rejected in hardware, so software never sees it.

Six filter banks hold eight configuration bytes each, plus a small control byte. Each bank has its own enable and its own scale. The scale decides how the eight bytes are split: one 32-bit filter, two 16-bit filters, four 8-bit filters, or one 16-bit and two 8-bit filters. Every filter is a value paired with a mask of the same width. The filter width sets which identifier bits the filter can test. Configuration is loaded one byte at a time through a simple write port.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is held and right after it, out_valid, out_accept and out_index are 0. Every bank is disabled with scale 00 and all bytes 0, so a frame sent right after reset is rejected.
- R2: out_valid is 1 exactly in the cycle after a cycle with frm_valid at 1, and 0 otherwise. Whenever out_valid is 0, out_accept and out_index are also 0.
- R3: Scale 11 gives one filter at position 0. Its key is {std_id[10:0], ide, ext_id[17:0], rtr, 1'b0}. Bytes 0..3 hold the value and bytes 4..7 hold the mask, with the lower-numbered byte more significant. The key's least significant bit is never compared.
- R4: Scale 10 gives two filters, each with key {std_id[10:0], rtr, ide, 3'b000}. Position 0 takes its value from bytes 0..1 and its mask from bytes 2..3. Position 1 takes its value from bytes 4..5 and its mask from bytes 6..7. ext_id and the three low key bits never affect these filters.
- R5: Scale 00 gives four filters that compare std_id[10:3] only. Position k takes its value from byte 2k and its mask from byte 2k+1.
- R6: Scale 01 gives a 16-bit filter at position 0 (laid out as in R4, bytes 0..3), and 8-bit filters at positions 1 (bytes 4..5) and 2 (bytes 6..7). Position 3 never matches.
- R7: A filter bit is compared only where its mask bit is 1. A mask bit of 0 makes that key bit don't-care.
- R8: When several filters match, the lowest bank wins, and within that bank the lowest position wins. out_index = 4*bank + position.
- R9: A bank whose enable is 0 never matches. A frame that no enabled filter matches gives out_valid 1, out_accept 0 and out_index 0.
- R10: A write with cfg_addr 0..7 loads that byte of bank cfg_bank. cfg_addr 8 loads the control byte: bits 1:0 are the scale and bit 2 is the enable. Writes with cfg_addr 9..15, or with cfg_bank 6 or 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 3 | Bank addressed by the write |
| cfg_addr | input | 4 | Byte 0..7, or 8 for the control byte |
| cfg_wdata | input | 8 | Write data |
| frm_valid | input | 1 | Frame fields valid this cycle |
| frm_std_id | input | 11 | Base identifier |
| frm_ext_id | input | 18 | Identifier extension |
| frm_ide | input | 1 | IDE flag of the frame |
| frm_rtr | input | 1 | RTR flag of the frame |
| out_valid | output | 1 | Decision strobe, one cycle after frm_valid |
| out_accept | output | 1 | Frame accepted |
| out_index | output | 5 | Global number of the winning filter |

## Verification
A wrong byte-to-filter mapping for one scale shows up as a wrong accept or a wrong index on the first frame that hits the affected bits. A priority fault shows up on the first frame that matches two filters. Stored configuration is the only long-lived state. A write that lands in the wrong place, or a stray write that is not ignored, stays hidden until a frame depends on the damaged byte. The bench therefore sends a dependent frame right after every stray write. Each decision appears on the ports exactly one cycle after its strobe, and the bench model compares the outputs in every cycle.

// File: rtl/can_filt_pkg.sv
// Package: shared constants and types of the CAN acceptance filter.
// Assumes the bank geometry is fixed: eight bytes and at most four filter slots per bank.
package can_filt_pkg;

    localparam int BYTES_PER_BANK = 8;
    localparam int SLOTS_PER_BANK = 4;
    localparam int SLOT_W         = 2;
    localparam int CTL_ADDR       = 8;

    // Split of a bank's eight bytes into filters.
    typedef enum logic [1:0] {
        SCALE_8X4  = 2'b00,
        SCALE_MIX  = 2'b01,
        SCALE_16X2 = 2'b10,
        SCALE_32X1 = 2'b11
    } scale_e;

    typedef struct packed {
        logic   en;
        scale_e scale;
    } bank_ctl_t;

    typedef struct packed {
        logic [10:0] std_id;
        logic [17:0] ext_id;
        logic        ide;
        logic        rtr;
    } frame_t;

    // Key compared by a 32-bit filter; the lowest bit is padding.
    function automatic logic [31:0] key_wide(input frame_t f);
        return {f.std_id, f.ide, f.ext_id, f.rtr, 1'b0};
    endfunction

    // Key compared by a 16-bit filter; the three lowest bits are padding.
    function automatic logic [15:0] key_half(input frame_t f);
        return {f.std_id, f.rtr, f.ide, 3'b000};
    endfunction

endpackage

// File: rtl/can_filt_cfg.sv
// Module: can_filt_cfg
// Holds the configuration bytes and the control byte of every bank.
// Assumes single-byte writes; an address or a bank outside the map is dropped.
module can_filt_cfg
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS = 6,
    parameter int BANK_W    = 3
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic                                               cfg_we,
    input  logic [BANK_W-1:0]                                  cfg_bank,
    input  logic [3:0]                                         cfg_addr,
    input  logic [7:0]                                         cfg_wdata,
    output logic [NUM_BANKS-1:0][BYTES_PER_BANK-1:0][7:0]      cfg_bytes,
    output bank_ctl_t [NUM_BANKS-1:0]                          bank_ctl
);

    logic wr_ok;
    logic is_byte;
    logic is_ctl;

    // Decode whether the write lands in the map at all.
    always_comb begin
        wr_ok   = cfg_we && (int'(cfg_bank) < NUM_BANKS);
        is_byte = (int'(cfg_addr) < BYTES_PER_BANK);
        is_ctl  = (int'(cfg_addr) == CTL_ADDR);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Store one bank's bytes and control, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_bytes[b]       <= '0;
                bank_ctl[b].en     <= 1'b0;
                bank_ctl[b].scale  <= SCALE_8X4;
            end else if (wr_ok && (int'(cfg_bank) == b)) begin
                if (is_byte) begin
                    cfg_bytes[b][cfg_addr[2:0]] <= cfg_wdata;
                end else if (is_ctl) begin
                    bank_ctl[b].en    <= cfg_wdata[2];
                    bank_ctl[b].scale <= scale_e'(cfg_wdata[1:0]);
                end
            end
        end
    end

    // R10: a write outside the map leaves all stored configuration untouched.
    a_r10_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ((int'(cfg_bank) >= NUM_BANKS) || (int'(cfg_addr) > CTL_ADDR)))
        |=> ($stable(cfg_bytes) && $stable(bank_ctl)));

endmodule

// File: rtl/can_filt_bank.sv
// Module: can_filt_bank
// Matches one frame against the filters of one bank at the bank's scale.
// Assumes configuration is stable while a frame is evaluated; purely combinational.
module can_filt_bank
    import can_filt_pkg::*;
(
    input  logic [BYTES_PER_BANK-1:0][7:0] bank_bytes,
    input  bank_ctl_t                      ctl,
    input  frame_t                         frm,
    output logic [SLOTS_PER_BANK-1:0]      hit
);

    localparam logic [31:0] WIDE_CARE = 32'hFFFF_FFFE;
    localparam logic [15:0] HALF_CARE = 16'hFFF8;
    localparam int          NUM_HALF  = BYTES_PER_BANK / 4;
    localparam int          NUM_NARROW = BYTES_PER_BANK / 2;

    logic [31:0]           k_wide;
    logic [15:0]           k_half;
    logic [7:0]            k_narrow;
    logic                  m_wide;
    logic [NUM_HALF-1:0]   m_half;
    logic [NUM_NARROW-1:0] m_narrow;

    // Form the keys each filter width compares.
    always_comb begin
        k_wide   = key_wide(frm);
        k_half   = key_half(frm);
        k_narrow = frm.std_id[10:3];
    end

    // Compare the single wide filter over all eight bytes.
    always_comb begin
        m_wide = (((k_wide ^ {bank_bytes[0], bank_bytes[1], bank_bytes[2], bank_bytes[3]})
                  & {bank_bytes[4], bank_bytes[5], bank_bytes[6], bank_bytes[7]}
                  & WIDE_CARE) == '0);
    end

    for (genvar j = 0; j < NUM_HALF; j++) begin : g_half
        // Compare one 16-bit filter taking value and mask from a four-byte group.
        always_comb begin
            m_half[j] = (((k_half ^ {bank_bytes[4*j], bank_bytes[4*j+1]})
                         & {bank_bytes[4*j+2], bank_bytes[4*j+3]}
                         & HALF_CARE) == '0);
        end
    end

    for (genvar k = 0; k < NUM_NARROW; k++) begin : g_narrow
        // Compare one 8-bit filter taking value and mask from a byte pair.
        always_comb begin
            m_narrow[k] = (((k_narrow ^ bank_bytes[2*k]) & bank_bytes[2*k+1]) == '0);
        end
    end

    // Route the comparator results to slot positions according to the scale.
    always_comb begin
        hit = '0;
        if (ctl.en) begin
            unique case (ctl.scale)
                SCALE_8X4:  hit = m_narrow;
                SCALE_MIX:  hit = {1'b0, m_narrow[3], m_narrow[2], m_half[0]};
                SCALE_16X2: hit = {2'b00, m_half};
                SCALE_32X1: hit = {3'b000, m_wide};
                default:    hit = '0;
            endcase
        end
    end

endmodule

// File: rtl/can_filt_prio.sv
// Module: can_filt_prio
// Picks the lowest-numbered set request and returns its number.
// Assumes the request vector is ordered bank-major, then by slot.
module can_filt_prio #(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set request is the last one kept.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/can_accept_filter.sv
// Module: can_accept_filter (top)
// Acceptance filter: registered accept decision and winning filter number,
// produced one clock after each frame strobe.
// Assumes the frame fields are valid only in the cycle frm_valid is high.
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS = 6,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int IDX_W     = $clog2(NUM_BANKS * SLOTS_PER_BANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BANK_W-1:0] cfg_bank,
    input  logic [3:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              frm_valid,
    input  logic [10:0]       frm_std_id,
    input  logic [17:0]       frm_ext_id,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    output logic              out_valid,
    output logic              out_accept,
    output logic [IDX_W-1:0]  out_index
);

    localparam int NHIT = NUM_BANKS * SLOTS_PER_BANK;

    logic [NUM_BANKS-1:0][BYTES_PER_BANK-1:0][7:0] cfg_bytes;
    bank_ctl_t [NUM_BANKS-1:0]                     bank_ctl;
    logic [NUM_BANKS-1:0]                          en_vec;
    logic [NHIT-1:0]                               hit_flat;
    logic                                          win_any;
    logic [IDX_W-1:0]                              win_idx;
    frame_t                                        frm;

    // Bundle the frame fields for the bank comparators.
    always_comb begin
        frm.std_id = frm_std_id;
        frm.ext_id = frm_ext_id;
        frm.ide    = frm_ide;
        frm.rtr    = frm_rtr;
    end

    can_filt_cfg #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_bank  (cfg_bank),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_bytes (cfg_bytes),
        .bank_ctl  (bank_ctl)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign en_vec[b] = bank_ctl[b].en;

        can_filt_bank u_bank (
            .bank_bytes (cfg_bytes[b]),
            .ctl        (bank_ctl[b]),
            .frm        (frm),
            .hit        (hit_flat[b*SLOTS_PER_BANK +: SLOTS_PER_BANK])
        );
    end

    can_filt_prio #(
        .N     (NHIT),
        .IDX_W (IDX_W)
    ) u_prio (
        .req (hit_flat),
        .any (win_any),
        .idx (win_idx)
    );

    // Register the decision; outputs read zero outside the result cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
            out_index  <= '0;
        end else begin
            out_valid  <= frm_valid;
            out_accept <= frm_valid && win_any;
            out_index  <= (frm_valid && win_any) ? win_idx : '0;
        end
    end

    // R2: each strobe yields a result in the very next cycle.
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> out_valid);

    // R2: no strobe, no result, and the result fields stay zero.
    a_r2_quiet_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> (!out_valid && !out_accept && out_index == '0));

    // R8: the reported filter had actually matched the frame.
    a_r8_winner_matched: assert property (@(posedge clk) disable iff (!rst_n)
        out_accept |-> ((($past(hit_flat) >> out_index) & NHIT'(1)) != '0));

    // R8: no lower-numbered filter had matched.
    a_r8_no_lower_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_accept |-> (($past(hit_flat) & ((NHIT'(1) << out_index) - NHIT'(1))) == '0));

    // R9: the winning bank was enabled when the frame was evaluated.
    a_r9_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        out_accept |-> ((($past(en_vec) >> (out_index >> SLOT_W)) & NUM_BANKS'(1)) != '0));

endmodule

// File: tb/sim_can_accept_filter.sv
`timescale 1ns/1ps
module sim_can_accept_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_bank = '0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        frm_valid = 1'b0;
    logic [10:0] frm_std_id = '0;
    logic [17:0] frm_ext_id = '0;
    logic        frm_ide = 1'b0;
    logic        frm_rtr = 1'b0;
    logic        out_valid;
    logic        out_accept;
    logic [4:0]  out_index;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    can_accept_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .frm_valid(frm_valid),
        .frm_std_id(frm_std_id), .frm_ext_id(frm_ext_id), .frm_ide(frm_ide),
        .frm_rtr(frm_rtr), .out_valid(out_valid), .out_accept(out_accept),
        .out_index(out_index)
    );

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_byte [6][8];
    bit [1:0] m_scale [6];
    bit       m_en [6];
    bit       exp_v = 0, exp_a = 0;
    int       exp_i = 0;
    bit       r_acc;
    int       r_idx;

    function automatic void filt_shape(input bit [1:0] sc, input int p, output int w, output int off);
        w = 0; off = 0;
        case (sc)
            2'b00: begin w = 8; off = 2 * p; end
            2'b01: if (p == 0) begin w = 16; off = 0; end
                   else if (p < 3) begin w = 8; off = 2 + 2 * p; end
            2'b10: if (p < 2) begin w = 16; off = 4 * p; end
            2'b11: if (p == 0) begin w = 32; off = 0; end
            default: w = 0;
        endcase
    endfunction

    function automatic bit filt_hit(input int b, input int p, input bit [10:0] s,
                                    input bit [17:0] e, input bit ide, input bit rtr);
        int w, off, n;
        bit [31:0] v, m, k;
        filt_shape(m_scale[b], p, w, off);
        if (w == 0) return 1'b0;
        n = w / 8; v = 0; m = 0;
        for (int q = 0; q < n; q++) begin
            v = (v << 8) | 32'(m_byte[b][off + q]);
            m = (m << 8) | 32'(m_byte[b][off + n + q]);
        end
        if (w == 32) begin k = {s, ide, e, rtr, 1'b0}; m[0] = 1'b0; end
        else if (w == 16) begin k = {16'h0, s, rtr, ide, 3'b000}; m[2:0] = 3'b000; end
        else k = {24'h0, s[10:3]};
        return ((k ^ v) & m) == 0;
    endfunction

    function automatic void ref_eval(input bit [10:0] s, input bit [17:0] e, input bit ide,
                                     input bit rtr, output bit acc, output int idx);
        acc = 0; idx = 0;
        for (int b = 0; b < 6; b++)
            for (int p = 0; p < 4; p++)
                if (!acc && m_en[b] && filt_hit(b, p, s, e, ide, rtr)) begin
                    acc = 1; idx = b * 4 + p;
                end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 6; b++) begin
                m_scale[b] <= 2'b00;
                m_en[b]    <= 1'b0;
                for (int q = 0; q < 8; q++) m_byte[b][q] <= 8'h00;
            end
            exp_v <= 0; exp_a <= 0; exp_i <= 0;
        end else begin
            ref_eval(frm_std_id, frm_ext_id, frm_ide, frm_rtr, r_acc, r_idx);
            exp_v <= frm_valid;
            exp_a <= frm_valid && r_acc;
            exp_i <= (frm_valid && r_acc) ? r_idx : 0;
            if (cfg_we && cfg_bank < 3'd6) begin
                if (cfg_addr < 4'd8) m_byte[cfg_bank][cfg_addr[2:0]] <= cfg_wdata;
                else if (cfg_addr == 4'd8) begin
                    m_scale[cfg_bank] <= cfg_wdata[1:0];
                    m_en[cfg_bank]    <= cfg_wdata[2];
                end
            end
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_valid !== exp_v || out_accept !== exp_a || out_index !== 5'(exp_i)) begin
                failures++;
                $display("FAIL %s model: actual v=%b a=%b i=%0d expected v=%b a=%b i=%0d",
                         cur_req, out_valid, out_accept, out_index, exp_v, exp_a, exp_i);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg_write(input int bank, input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 3'(bank); cfg_addr = 4'(addr); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_field(input int bank, input int start, input bit [31:0] v, input int n);
        for (int q = 0; q < n; q++) cfg_write(bank, start + q, int'(v >> (8 * (n - 1 - q))) & 255);
    endtask

    task automatic send(input bit [10:0] s, input bit [17:0] e, input bit ide, input bit rtr,
                        input bit ea, input int ei, input string req);
        @(negedge clk);
        cur_req = req;
        frm_valid = 1'b1; frm_std_id = s; frm_ext_id = e; frm_ide = ide; frm_rtr = rtr;
        @(negedge clk);
        frm_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || out_accept !== ea || out_index !== 5'(ei)) begin
            failures++;
            $display("FAIL %s frame std=%h: actual v=%b a=%b i=%0d expected v=1 a=%b i=%0d",
                     req, s, out_valid, out_accept, out_index, ea, ei);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    // ---------------- directed and random sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        checks++;  // R1 outputs held low in reset
        if (out_valid !== 1'b0 || out_accept !== 1'b0 || out_index !== 5'd0) begin
            failures++;
            $display("FAIL R1 reset: actual v=%b a=%b i=%0d expected 0 0 0", out_valid, out_accept, out_index);
        end
        rst_n = 1'b1;
        send(11'h123, 18'h2ABCD, 1, 0, 0, 0, "R1");

        // R3: bank 0, one wide filter, exact match on everything
        cur_req = "R10";
        wr_field(0, 0, {11'h123, 1'b1, 18'h2ABCD, 1'b0, 1'b0}, 4);
        wr_field(0, 4, 32'hFFFF_FFFF, 4);
        cfg_write(0, 8, 3'b111);
        send(11'h123, 18'h2ABCD, 1, 0, 1, 0, "R3");
        send(11'h123, 18'h2ABCC, 1, 0, 0, 0, "R3");
        send(11'h123, 18'h2ABCD, 1, 1, 0, 0, "R3");
        send(11'h123, 18'h2ABCD, 0, 0, 0, 0, "R3");
        // R7: clear mask over the extension bits
        wr_field(0, 4, {11'h7FF, 1'b1, 18'h0, 1'b1, 1'b0}, 4);
        send(11'h123, 18'h00000, 1, 0, 1, 0, "R7");
        send(11'h122, 18'h00000, 1, 0, 0, 0, "R7");

        // R4: bank 1, two 16-bit filters
        wr_field(1, 0, {11'h700, 1'b0, 1'b0, 3'b000, 16'hFFFF}, 4);
        wr_field(1, 4, {11'h055, 1'b1, 1'b0, 3'b000, 16'hFFFF}, 4);
        cfg_write(1, 8, 3'b110);
        send(11'h055, 18'h12345, 0, 1, 1, 5, "R4");
        send(11'h055, 18'h3FFFF, 0, 1, 1, 5, "R4");
        send(11'h055, 18'h12345, 1, 1, 0, 0, "R4");
        send(11'h700, 18'h00001, 0, 0, 1, 4, "R4");

        // R5: bank 2, four 8-bit filters
        wr_field(2, 0, 32'hFFFF_FFFF, 4);
        wr_field(2, 4, 32'h5AFF_5AF0, 4);
        cfg_write(2, 8, 3'b100);
        send(11'h2D5, 18'h00000, 0, 0, 1, 10, "R5");
        send(11'h2D5, 18'h3FFFF, 1, 1, 1, 10, "R5");
        send(11'h2C8, 18'h00000, 0, 0, 1, 11, "R7");
        send(11'h1D0, 18'h00000, 0, 0, 0, 0, "R5");
        // R8: a lower slot in the same bank now also matches
        wr_field(2, 2, 32'h0000_50F0, 2);
        send(11'h2D5, 18'h00000, 0, 0, 1, 9, "R8");

        // R6: bank 3, one 16-bit and two 8-bit filters
        wr_field(3, 0, {11'h3C3, 1'b0, 1'b1, 3'b000, 16'hFFFF}, 4);
        wr_field(3, 4, 32'h11FF_110F, 4);
        cfg_write(3, 8, 3'b101);
        send(11'h3C3, 18'h00000, 1, 0, 1, 12, "R6");
        send(11'h3C3, 18'h00000, 1, 1, 0, 0, "R6");
        send(11'h08B, 18'h00000, 0, 0, 1, 13, "R6");
        send(11'h108, 18'h00000, 0, 0, 1, 14, "R6");

        // R8: bank 5 accepts everything but only wins when nothing lower matches
        cfg_write(5, 8, 3'b100);
        send(11'h000, 18'h00000, 0, 0, 1, 20, "R8");
        send(11'h123, 18'h2ABCD, 1, 0, 1, 0, "R8");

        // R10: stray writes change nothing
        cfg_write(0, 9, 8'h00);
        cfg_write(0, 15, 8'h00);
        cfg_write(6, 8, 8'h07);
        cfg_write(7, 0, 8'hAA);
        send(11'h123, 18'h2ABCD, 1, 0, 1, 0, "R10");
        send(11'h000, 18'h00000, 0, 0, 1, 20, "R10");

        // R9: disabling banks
        cfg_write(0, 8, 3'b011);
        send(11'h123, 18'h2ABCD, 1, 0, 1, 20, "R9");
        cfg_write(5, 8, 3'b000);
        send(11'h123, 18'h2ABCD, 1, 0, 0, 0, "R9");

        // R2: random frames and writes, checked by the model every cycle
        cur_req = "R2";
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            frm_valid  = 1'($urandom);
            frm_std_id = 11'($urandom);
            frm_ext_id = 18'($urandom);
            frm_ide    = 1'($urandom);
            frm_rtr    = 1'($urandom);
            cfg_we     = (($urandom % 4) == 0);
            cfg_bank   = 3'($urandom);
            cfg_addr   = 4'($urandom);
            cfg_wdata  = 8'($urandom);
        end
        @(negedge clk);
        frm_valid = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule